// File: doc/BRIEF.md
# Two-Wire Clock Generator Control Slave

This block is the serial configuration port of a clock generator. It sits on a two-wire bus, with SCL as an input and SDA as an open-drain line. A system clock that runs much faster than SCL oversamples both lines. The block holds six 8-bit control registers. Their flops drive the output enables and the frequency-select and spread-spectrum controls of the generator.

A write transaction carries two fixed framing bytes before any data: a command byte and a byte count. The slave acknowledges both and ignores their values. After them, data bytes land in register 0, then register 1, and so on. A read transaction returns register 0 upward immediately after the address acknowledge. Two register bits are read-only and mirror inverted strap levels that were latched at power-up. Four decoded fields of register 0 are also brought out as dedicated pins.

Top module: `clkgen_ctrl_slave`

## Requirements
- R1: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF, apart from the read-only strap bits (see R6). SDA is not driven.
- R2: Only the 7-bit address 1101001 is acknowledged (byte 0xD2 to write, 0xD3 to read). For any other address the slave holds SDA released until the next START, and it neither acknowledges nor stores any byte that follows.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Each later byte is acknowledged and stored into register 0, 1, 2, ... in order.
- R4: Write data bytes beyond register 5 are acknowledged and discarded, and no register changes.
- R5: In a read, the slave sends register 0, 1, 2, ... MSB first, starting right after the address acknowledge. A byte requested beyond register 5 reads 0x00. After a master NACK the slave releases SDA.
- R6: Register 1 bit 7 always equals the inverse of the FS2 strap input, and register 4 bit 3 the inverse of the FS1 strap input. Writes to these bits have no effect.
- R7: A START, including a repeated START inside a transaction, restarts the sequence, so that the next data byte goes to or comes from register 0.
- R8: The register 0 decode pins are: spread_wide_o = bit 7; sw_fsel_o[2:0] = bits 6:4; sw_fsel_o[3] = bit 2; sw_fsel_en_o = bit 3; spread_en_o = bit 1; outputs_hiz_o = bit 0.
- R9: An SCL or SDA pulse shorter than FILT_LEN system clocks is rejected and does not disturb a transfer.
- R10: The slave changes its SDA drive only while SCL is low, and sda_o is always 0 (open drain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data line output value, tied low |
| sda_oe | output | 1 | Drive the data line low when 1 |
| strap_fs2_i | input | 1 | Latched FS2 strap level |
| strap_fs1_i | input | 1 | Latched FS1 strap level |
| cfg_o | output | NUM_REGS*8 | Register contents, register i in bits 8i+7:8i |
| spread_wide_o | output | 1 | Spread depth select (register 0 bit 7) |
| sw_fsel_o | output | 4 | Software frequency select code |
| sw_fsel_en_o | output | 1 | Software frequency selection enabled |
| spread_en_o | output | 1 | Spread spectrum enabled |
| outputs_hiz_o | output | 1 | Tri-state all generator outputs |

## Verification
If the byte counter or register pointer is wrong, data lands one register off. This shows on cfg_o within about ten system clocks of the ACK falling edge. A framing byte that is stored by mistake, or a dropped byte, shows the same way. A wrong address decision or phase shows at the next acknowledge clock, as a missing or extra low on SDA. A read pointer error shows in the very first bit of the returned byte. A broken filter would let a single-cycle SCL spike count as a bit, and that shifts every later bit of the write.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RX     = 3'd1,
    PH_RX_ACK = 3'd2,
    PH_TX     = 3'd3,
    PH_TX_ACK = 3'd4,
    PH_IGNORE = 3'd5
  } phase_t;

  // Byte position inside a write: address, command, count, then data.
  localparam logic [1:0] BYTE_ADDR = 2'd0;
  localparam logic [1:0] BYTE_DATA = 2'd3;

  function automatic logic [7:0] reg_reset_value(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  // Bits that mirror inverted strap levels instead of stored data.
  function automatic logic [7:0] reg_ro_mask(input int idx);
    if (idx == 1) return 8'h80;
    if (idx == 4) return 8'h08;
    return 8'h00;
  endfunction

endpackage

// File: rtl/ccs_line_filter.sv
module ccs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CNT_W      = $clog2(FILT_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // The filtered level follows only after FILT_LEN steady samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= 1'b1;
      hold_cnt <= '0;
    end else if (sync_q[SYNC_STAGES-1] == level_q) begin
      hold_cnt <= '0;
    end else if (hold_cnt == CNT_W'(FILT_LEN - 1)) begin
      level_q  <= sync_q[SYNC_STAGES-1];
      hold_cnt <= '0;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign line_o = level_q;

endmodule

// File: rtl/ccs_bus_engine.sv
module ccs_bus_engine
  import ccs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int NUM_REGS           = 6,
  localparam int PTR_W             = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output phase_t           phase_o
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  phase_t           phase;
  logic             scl_p, sda_p;
  logic             scl_rise, scl_fall, bus_start, bus_stop;
  logic [2:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh;
  logic             rx_full;
  logic [1:0]       byte_pos;
  logic [PTR_W-1:0] ptr;
  logic             is_read;
  logic             master_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign bus_start = scl_f & scl_p & sda_p & ~sda_f;
  assign bus_stop  = scl_f & scl_p & ~sda_p & sda_f;

  assign rd_idx  = ptr;
  assign phase_o = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_full    <= 1'b0;
      byte_pos   <= BYTE_ADDR;
      ptr        <= '0;
      is_read    <= 1'b0;
      master_ack <= 1'b0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        phase    <= PH_RX;
        bit_cnt  <= '0;
        rx_full  <= 1'b0;
        byte_pos <= BYTE_ADDR;
        ptr      <= '0;
        is_read  <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (bus_stop) begin
        phase   <= PH_IDLE;
        rx_full <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              if (byte_pos == BYTE_ADDR) begin
                if (rx_sh[7:1] == SLAVE_ADDR) begin
                  sda_oe   <= 1'b1;
                  is_read  <= rx_sh[0];
                  byte_pos <= byte_pos + 1'b1;
                  phase    <= PH_RX_ACK;
                end else begin
                  phase <= PH_IGNORE;
                end
              end else begin
                sda_oe <= 1'b1;
                phase  <= PH_RX_ACK;
                if (byte_pos != BYTE_DATA) begin
                  byte_pos <= byte_pos + 1'b1;
                end else if (ptr != PTR_END) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr + 1'b1;
                end
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                if (ptr != PTR_END) ptr <= ptr + 1'b1;
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                phase   <= PH_TX_ACK;
              end else begin
                tx_sh   <= {tx_sh[6:0], 1'b0};
                sda_oe  <= ~tx_sh[6];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (master_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                if (ptr != PTR_END) ptr <= ptr + 1'b1;
                phase  <= PH_TX;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ccs_regfile.sv
module ccs_regfile
  import ccs_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int PTR_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  strap_fs2,
  input  logic                  strap_fs1,
  input  logic [PTR_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0] strap_bits;
  assign strap_bits = {~strap_fs2, 3'b000, ~strap_fs1, 3'b000};

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [7:0] RO_M  = reg_ro_mask(gi);
    localparam logic [7:0] RST_V = reg_reset_value(gi);
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= (RST_V & ~RO_M) | (strap_bits & RO_M);
      else if (wr_en && wr_idx == PTR_W'(gi))
        q <= (wr_data & ~RO_M) | (strap_bits & RO_M);
      else
        q <= (q & ~RO_M) | (strap_bits & RO_M);
    end

    assign regs_flat[gi*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == PTR_W'(i)) rd_data = regs_flat[i*8 +: 8];
    end
  end

endmodule

// File: rtl/clkgen_ctrl_slave.sv
module clkgen_ctrl_slave
  import ccs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int NUM_REGS           = 6,
  parameter int SYNC_STAGES        = 2,
  parameter int FILT_LEN           = 4,
  localparam int PTR_W             = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_o,
  output logic                  sda_oe,
  input  logic                  strap_fs2_i,
  input  logic                  strap_fs1_i,
  output logic [NUM_REGS*8-1:0] cfg_o,
  output logic                  spread_wide_o,
  output logic [3:0]            sw_fsel_o,
  output logic                  sw_fsel_en_o,
  output logic                  spread_en_o,
  output logic                  outputs_hiz_o
);

  logic [1:0]       line_raw, line_flt;
  logic             scl_flt, sda_flt;
  logic [7:0]       rd_data;
  logic [PTR_W-1:0] rd_idx, wr_idx;
  logic             wr_en;
  logic [7:0]       wr_data;
  phase_t           eng_phase;

  assign line_raw = {sda_i, scl_i};

  for (genvar gl = 0; gl < 2; gl++) begin : g_line
    ccs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(line_raw[gl]),
      .line_o(line_flt[gl])
    );
  end

  assign scl_flt = line_flt[0];
  assign sda_flt = line_flt[1];

  ccs_bus_engine #(
    .SLAVE_ADDR(SLAVE_ADDR),
    .NUM_REGS  (NUM_REGS)
  ) u_engine (
    .clk    (clk),
    .rst    (rst),
    .scl_f  (scl_flt),
    .sda_f  (sda_flt),
    .rd_data(rd_data),
    .rd_idx (rd_idx),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .sda_oe (sda_oe),
    .phase_o(eng_phase)
  );

  ccs_regfile #(
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .strap_fs2(strap_fs2_i),
    .strap_fs1(strap_fs1_i),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .regs_flat(cfg_o)
  );

  assign sda_o         = 1'b0;
  assign spread_wide_o = cfg_o[7];
  assign sw_fsel_o     = {cfg_o[2], cfg_o[6:4]};
  assign sw_fsel_en_o  = cfg_o[3];
  assign spread_en_o   = cfg_o[1];
  assign outputs_hiz_o = cfg_o[0];

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
  import ccs_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int PTR_W   = $clog2(NUM_REGS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_f,
  input logic                  sda_oe,
  input phase_t                phase,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] cfg,
  input logic                  strap_fs2,
  input logic                  strap_fs1
);

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(rst)) |-> (cfg[7:0] == 8'h00 && cfg[23:16] == 8'hFF)); // R1

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && phase == PH_IGNORE && $past(phase) == PH_IGNORE) |-> !sda_oe); // R2

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < PTR_W'(NUM_REGS))); // R4

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R10

  AST_RO_FS2: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> (cfg[15] == ~$past(strap_fs2))); // R6

  AST_RO_FS1: assert property (@(posedge clk) disable iff (rst)
    seen_rst |-> (cfg[35] == ~$past(strap_fs1))); // R6

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_hold
    localparam logic [7:0] KEEP = ~reg_ro_mask(gi);
    AST_REG_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (seen_rst && !$past(rst) && !$past(wr_en && wr_idx == PTR_W'(gi)))
        |-> ((cfg[gi*8 +: 8] & KEEP) == ($past(cfg[gi*8 +: 8]) & KEEP))); // R3
  end

endmodule

bind clkgen_ctrl_slave ccs_checker #(.NUM_REGS(NUM_REGS)) u_ccs_checker (
  .clk      (clk),
  .rst      (rst),
  .scl_f    (scl_flt),
  .sda_oe   (sda_oe),
  .phase    (eng_phase),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .cfg      (cfg_o),
  .strap_fs2(strap_fs2_i),
  .strap_fs1(strap_fs1_i)
);

// File: tb/tb_clkgen_ctrl_slave.sv
module tb_clkgen_ctrl_slave;

  localparam int NREG = 6;
  localparam int Q    = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            scl = 1'b1;
  logic            sda_m = 1'b1;
  logic            fs2 = 1'b0, fs1 = 1'b0;
  logic            sda_line;
  logic            sda_o, sda_oe;
  logic [NREG*8-1:0] cfg_o;
  logic            spread_wide_o, sw_fsel_en_o, spread_en_o, outputs_hiz_o;
  logic [3:0]      sw_fsel_o;

  int n_chk = 0, n_fail = 0, sda_violations = 0;
  bit finished = 0;
  logic [7:0] exp_reg [NREG];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~(sda_oe & ~sda_o);

  clkgen_ctrl_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe),
    .strap_fs2_i(fs2), .strap_fs1_i(fs1), .cfg_o(cfg_o),
    .spread_wide_o(spread_wide_o), .sw_fsel_o(sw_fsel_o),
    .sw_fsel_en_o(sw_fsel_en_o), .spread_en_o(spread_en_o),
    .outputs_hiz_o(outputs_hiz_o)
  );

  // R10: the slave's drive must not change while SCL is high
  always @(sda_oe) if (!rst && scl) sda_violations++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] view(input int i);
    logic [7:0] v = exp_reg[i];
    if (i == 1) v[7] = ~fs2;
    if (i == 4) v[3] = ~fs1;
    return v;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(cfg_o[i*8 +: 8] == view(i), req, cfg_o[i*8 +: 8], view(i));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        wq(Q/2); scl = 1'b1; wq(1); scl = 1'b0; wq(Q/2 - 1);
      end else begin
        wq(Q);
      end
      scl = 1'b1; wq(2*Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  // Writes address 0xD2, the two framing bytes, then n data bytes.
  task automatic write_seq(input int n, input logic [7:0] d [10], input bit glitch, input string req);
    bit a;
    bus_start();
    send_byte(8'hD2, glitch, a); check(a, req, a, 1);
    send_byte(8'h5C, glitch, a); check(a, req, a, 1);
    send_byte(8'hE1, glitch, a); check(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], glitch, a);
      check(a, req, a, 1);
      if (i < NREG) exp_reg[i] = d[i];
    end
    bus_stop();
    wq(4);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    for (int i = 0; i < NREG; i++) exp_reg[i] = (i == 0) ? 8'h00 : 8'hFF;
    check_regs("R1");
    check({spread_wide_o, sw_fsel_o, sw_fsel_en_o, spread_en_o, outputs_hiz_o} == 9'd0,
          "R8", {spread_wide_o, sw_fsel_o, sw_fsel_en_o, spread_en_o, outputs_hiz_o}, 0);
  endtask

  task automatic t_write();
    logic [7:0] d [10] = '{8'hA5, 8'h3C, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_seq(3, d, 0, "R3");
    check_regs("R3");
  endtask

  task automatic t_decode();
    logic [7:0] d [10] = '{8'hDA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_seq(1, d, 0, "R8");
    check(spread_wide_o == 1'b1, "R8", spread_wide_o, 1);
    check(sw_fsel_o == 4'b0101, "R8", sw_fsel_o, 4'b0101);
    check(sw_fsel_en_o == 1'b1, "R8", sw_fsel_en_o, 1);
    check(spread_en_o == 1'b1, "R8", spread_en_o, 1);
    check(outputs_hiz_o == 1'b0, "R8", outputs_hiz_o, 0);
  endtask

  task automatic t_overflow();
    logic [7:0] d [10];
    for (int i = 0; i < 10; i++) d[i] = 8'h10 + 8'(i);
    write_seq(10, d, 0, "R4");
    check_regs("R4");
  endtask

  task automatic t_foreign();
    bit a;
    logic [7:0] addrs [2] = '{8'hD0, 8'hA4};
    for (int k = 0; k < 2; k++) begin
      bus_start();
      send_byte(addrs[k], 0, a); check(!a, "R2", a, 0);
      send_byte(8'h00, 0, a);    check(!a, "R2", a, 0);
      send_byte(8'h00, 0, a);    check(!a, "R2", a, 0);
      send_byte(8'h77, 0, a);    check(!a, "R2", a, 0);
      bus_stop();
      wq(4);
      check_regs("R2");
    end
  endtask

  task automatic t_ro();
    logic [7:0] d [10];
    fs2 = 1'b1; fs1 = 1'b1;
    wq(10);
    check(cfg_o[15] == 1'b0, "R6", cfg_o[15], 0);
    check(cfg_o[35] == 1'b0, "R6", cfg_o[35], 0);
    for (int i = 0; i < 10; i++) d[i] = (i < NREG) ? exp_reg[i] : 8'h00;
    d[1] = 8'hFF; d[4] = 8'hFF;
    write_seq(5, d, 0, "R6");
    check(cfg_o[15:8] == 8'h7F, "R6", cfg_o[15:8], 8'h7F);
    check(cfg_o[39:32] == 8'hF7, "R6", cfg_o[39:32], 8'hF7);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, 0, a); check(a, "R5", a, 1);
    for (int i = 0; i <= NREG; i++) begin
      recv_byte(i != NREG, b);
      check(b == ((i < NREG) ? view(i) : 8'h00), "R5", b, (i < NREG) ? view(i) : 8'h00);
    end
    check(sda_oe == 1'b0, "R5", sda_oe, 0);
    bus_stop();
    wq(4);
  endtask

  task automatic t_restart();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, 0, a); send_byte(8'h00, 0, a); send_byte(8'h00, 0, a);
    send_byte(8'h11, 0, a); send_byte(8'h22, 0, a);
    bus_start();
    send_byte(8'hD2, 0, a); send_byte(8'h00, 0, a); send_byte(8'h00, 0, a);
    send_byte(8'h33, 0, a); check(a, "R7", a, 1);
    bus_stop();
    wq(4);
    exp_reg[0] = 8'h33; exp_reg[1] = 8'h22;
    check_regs("R7");
    bus_start();
    send_byte(8'hD2, 0, a); send_byte(8'h00, 0, a); send_byte(8'h00, 0, a);
    send_byte(8'h44, 0, a);
    bus_start();
    send_byte(8'hD3, 0, a); check(a, "R7", a, 1);
    recv_byte(0, b);
    check(b == 8'h44, "R7", b, 8'h44);
    bus_stop();
    wq(4);
    exp_reg[0] = 8'h44;
  endtask

  task automatic t_glitch();
    logic [7:0] d [10] = '{8'h96, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    write_seq(1, d, 1, "R9");
    check(cfg_o[7:0] == 8'h96, "R9", cfg_o[7:0], 8'h96);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wq(10);
    rst = 1'b0;
    wq(5);
    t_reset();
    t_write();
    t_decode();
    t_overflow();
    t_foreign();
    t_ro();
    t_read();
    t_restart();
    t_glitch();
    check(sda_violations == 0, "R10", sda_violations, 0);
    check(sda_o == 1'b0, "R10", sda_o, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule